// File: doc/BRIEF.md
# PUF Response Stability Analyser

This block watches a stream of wide responses read back from an array of physically unclonable bit cells and gathers the figures needed to judge how repeatable that array is. After a clear command, the first response to arrive is held as the golden key. The block also counts the ones in that key, so the host can judge bias against the ideal of one half. Every later response is XORed with the golden key. The ones in that difference are counted by a short pipelined adder tree and added into a running intra-device distance total.

The same difference vector is ORed into a sticky per-cell mask. A cell that disagrees with the golden key even once during the run stays flagged until the next clear. The number of flagged cells is reported as well. The clear command also latches how many comparison responses make up one measurement run. Once that many have been counted through the pipeline, a done flag rises and further responses are ignored.

The host divides the distance total by the response count times the response width to get the average error. Reliability is one minus that average. The block itself performs no division.

Top module: `puf_stability_analyser`

## Requirements
- R1: After reset, and after any clear, the unstable mask, unstable count, distance total and ones count all read zero and done is low; after reset the run length is 1000 comparison responses.
- R2: The first response accepted after a clear or reset becomes the golden key and is not compared. The ones count then equals the number of 1 bits in that response, and the mask and distance total stay zero.
- R3: For every accepted comparison response, the distance total grows by the number of bit positions in which that response differs from the golden key. No wrap is allowed for run lengths up to 1023 with 128-bit responses.
- R4: Mask bit i becomes 1 when any accepted comparison response differs from the golden key at bit i. It stays 1 until the next clear.
- R5: The unstable count always equals the number of 1 bits in the mask; with every cell unstable it reads 128.
- R6: The run length is taken from target_cnt in the cycle clr is high. Done rises only after exactly that many comparison responses have been accepted and their distances summed; done stays low while any is still in flight.
- R7: While done is high, responses are ignored: mask, distance total, ones count and done do not change.
- R8: clr takes priority over a response offered in the same cycle. That response is neither compared nor captured, so the next response becomes the golden key. clr also discards comparisons still in the pipeline, so they never reach the distance total.
- R9: A comparison accepted on a clock edge appears in the distance total on the fourth rising edge, counting the accepting edge as the first. The mask is updated on the accepting edge itself.
- R10: With a run length of zero, done rises right after the golden key is captured, and no response is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear; latches target_cnt and arms golden capture |
| target_cnt | input | 10 | Number of comparison responses in a run, sampled with clr |
| in_valid | input | 1 | in_resp carries a response this cycle |
| in_resp | input | 128 | Response word from the bit-cell array |
| unstable_mask | output | 128 | Sticky per-cell disagreement flags |
| unstable_cnt | output | 8 | Number of set bits in unstable_mask |
| dist_total | output | 18 | Summed Hamming distance of all compared responses |
| ones_cnt | output | 8 | Number of 1 bits in the golden key |
| done | output | 1 | Programmed number of comparisons fully processed |

## Verification
The bench aims at the golden capture boundary. A design that compared the first response, or kept the one offered together with clr, would show a non-zero distance or a wrong ones count. It times the distance update to the exact edge and checks that done waits for the pipeline to drain. A late or early tap, or a done taken from the accept counter alone, would move the update or raise done before the sum is final. It also fires clr while comparisons are in flight, offers responses after done, and runs with a zero run length. A design that leaks flushed work, keeps counting after done, or hangs before done with no comparisons would change totals that must stay fixed. Finally, an all-ones golden key against an all-zeros response drives every cell unstable, so an unstable or ones counter that is one bit too narrow would wrap.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2
  } psa_state_e;

  function automatic int unsigned count_width(input int unsigned max_value);
    return $clog2(max_value + 1);
  endfunction

endpackage

// File: rtl/psa_popcount_pipe.sv
module psa_popcount_pipe #(
  parameter int W  = 128,
  parameter int G1 = 8,
  parameter int G2 = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     in_valid,
  input  logic [W-1:0]             in_vec,
  output logic                     out_valid,
  output logic [$clog2(W+1)-1:0]   out_cnt,
  output logic                     busy
);
  localparam int N1    = W / G1;
  localparam int N2    = N1 / G2;
  localparam int S1_W  = psa_pkg::count_width(G1);
  localparam int S2_W  = psa_pkg::count_width(G1 * G2);
  localparam int OUT_W = $clog2(W + 1);

  function automatic logic [S1_W-1:0] ones_in_group(input logic [G1-1:0] v);
    logic [S1_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < G1; i++) acc = acc + S1_W'(v[i]);
    return acc;
  endfunction

  logic [S1_W-1:0] s1_q [N1];
  logic [S2_W-1:0] s2_q [N2];
  logic [OUT_W-1:0] s3_q;
  logic [2:0]       v_q;

  for (genvar g = 0; g < N1; g++) begin : g_stage1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_q[g] <= '0;
      else if (in_valid) s1_q[g] <= ones_in_group(in_vec[g*G1 +: G1]);
    end
  end

  for (genvar g = 0; g < N2; g++) begin : g_stage2
    logic [S2_W-1:0] grp_sum;
    always_comb begin
      grp_sum = '0;
      for (int k = 0; k < G2; k++) grp_sum = grp_sum + S2_W'(s1_q[g*G2 + k]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_q[g] <= '0;
      else if (v_q[0]) s2_q[g] <= grp_sum;
    end
  end

  logic [OUT_W-1:0] total_c;
  always_comb begin
    total_c = '0;
    for (int k = 0; k < N2; k++) total_c = total_c + OUT_W'(s2_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_q <= '0;
    else if (v_q[1]) s3_q <= total_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else if (flush) v_q <= '0;
    else v_q <= {v_q[1:0], in_valid};
  end

  assign out_valid = v_q[2];
  assign out_cnt   = s3_q;
  assign busy      = |v_q;

  p_stage1_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[0] && !flush) |=> v_q[1]);
  p_stage2_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[1] && !flush) |=> out_valid);
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);

endmodule

// File: rtl/psa_golden_reg.sv
module psa_golden_reg #(
  parameter int W = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   capture,
  input  logic [W-1:0]           resp,
  output logic [W-1:0]           golden,
  output logic [$clog2(W+1)-1:0] ones
);
  localparam int OW = $clog2(W + 1);

  function automatic logic [OW-1:0] bit_total(input logic [W-1:0] v);
    logic [OW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) acc = acc + OW'(v[i]);
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      golden <= '0;
      ones   <= '0;
    end else if (clr) begin
      golden <= '0;
      ones   <= '0;
    end else if (capture) begin
      golden <= resp;
      ones   <= bit_total(resp);
    end
  end

  p_golden_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !capture) |=> ($stable(golden) && $stable(ones)));
  p_ones_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= OW'(W));

endmodule

// File: rtl/psa_run_ctrl.sv
module psa_run_ctrl #(
  parameter int          CNT_W          = 10,
  parameter int unsigned DEFAULT_TARGET = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] target_cnt,
  input  logic             in_valid,
  input  logic             pipe_busy,
  output logic             capture,
  output logic             accept,
  output logic             done
);
  import psa_pkg::*;

  psa_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target_q;
  logic             quota_open;
  logic             finished;

  assign quota_open = (cnt_q < target_q);
  assign capture    = in_valid && !clr && (state_q == ST_ARMED);
  assign accept     = in_valid && !clr && (state_q == ST_RUN) && quota_open;
  assign finished   = (state_q == ST_RUN) && !quota_open && !pipe_busy;
  assign done       = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ARMED;
      cnt_q    <= '0;
      target_q <= CNT_W'(DEFAULT_TARGET);
    end else if (clr) begin
      state_q  <= ST_ARMED;
      cnt_q    <= '0;
      target_q <= target_cnt;
    end else begin
      if (capture) state_q <= ST_RUN;
      else if (finished) state_q <= ST_DONE;
      if (accept) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= target_q);
  p_no_early_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_busy && !clr) |=> !$rose(done));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
  p_single_role_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && accept));

endmodule

// File: rtl/puf_stability_analyser.sv
module puf_stability_analyser #(
  parameter int          RESP_W         = 128,
  parameter int          CNT_W          = 10,
  parameter int unsigned DEFAULT_TARGET = 1000,
  parameter int          UC_W           = $clog2(RESP_W + 1),
  parameter int          DIST_W         = CNT_W + UC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  target_cnt,
  input  logic              in_valid,
  input  logic [RESP_W-1:0] in_resp,
  output logic [RESP_W-1:0] unstable_mask,
  output logic [UC_W-1:0]   unstable_cnt,
  output logic [DIST_W-1:0] dist_total,
  output logic [UC_W-1:0]   ones_cnt,
  output logic              done
);

  function automatic logic [UC_W-1:0] flagged_cells(input logic [RESP_W-1:0] m);
    logic [UC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < RESP_W; i++) acc = acc + UC_W'(m[i]);
    return acc;
  endfunction

  logic              capture;
  logic              accept;
  logic              pipe_busy;
  logic              pc_valid;
  logic [UC_W-1:0]   pc_cnt;
  logic [RESP_W-1:0] golden;
  logic [RESP_W-1:0] diff_vec;
  logic [RESP_W-1:0] mask_q;
  logic [DIST_W-1:0] dist_q;

  psa_run_ctrl #(
    .CNT_W          (CNT_W),
    .DEFAULT_TARGET (DEFAULT_TARGET)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .target_cnt (target_cnt),
    .in_valid   (in_valid),
    .pipe_busy  (pipe_busy),
    .capture    (capture),
    .accept     (accept),
    .done       (done)
  );

  psa_golden_reg #(.W(RESP_W)) i_golden (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .capture (capture),
    .resp    (in_resp),
    .golden  (golden),
    .ones    (ones_cnt)
  );

  assign diff_vec = in_resp ^ golden;

  psa_popcount_pipe #(.W(RESP_W)) i_popcount (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (clr),
    .in_valid  (accept),
    .in_vec    (diff_vec),
    .out_valid (pc_valid),
    .out_cnt   (pc_cnt),
    .busy      (pipe_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (clr) mask_q <= '0;
    else if (accept) mask_q <= mask_q | diff_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= '0;
    else if (clr) dist_q <= '0;
    else if (pc_valid) dist_q <= dist_q + DIST_W'(pc_cnt);
  end

  assign unstable_mask = mask_q;
  assign unstable_cnt  = flagged_cells(mask_q);
  assign dist_total    = dist_q;

  p_mask_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(mask_q) & ~mask_q) == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (dist_q >= $past(dist_q)));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unstable_cnt <= UC_W'(RESP_W));
  p_frozen_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(mask_q) && $stable(dist_q) && $stable(ones_cnt)));
  p_capture_no_compare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ($stable(mask_q) && $stable(dist_q)));
  p_clear_zeroes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask_q == '0 && dist_q == '0 && !done));

endmodule

// File: tb/test_puf_stability_analyser.sv
`timescale 1ns/1ps
module test_puf_stability_analyser;
  localparam int RESP_W = 128;
  localparam int CNT_W  = 10;
  localparam int UC_W   = 8;
  localparam int DIST_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0;
  logic [CNT_W-1:0]  target_cnt = '0;
  logic              in_valid = 1'b0;
  logic [RESP_W-1:0] in_resp = '0;
  logic [RESP_W-1:0] unstable_mask;
  logic [UC_W-1:0]   unstable_cnt;
  logic [DIST_W-1:0] dist_total;
  logic [UC_W-1:0]   ones_cnt;
  logic              done;

  always #4 clk = ~clk;

  puf_stability_analyser i_puf_stability_analyser (
    .clk (clk), .rst_n (rst_n), .clr (clr), .target_cnt (target_cnt),
    .in_valid (in_valid), .in_resp (in_resp),
    .unstable_mask (unstable_mask), .unstable_cnt (unstable_cnt),
    .dist_total (dist_total), .ones_cnt (ones_cnt), .done (done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench-side model
  bit                m_armed;
  logic [RESP_W-1:0] m_golden;
  logic [RESP_W-1:0] m_mask;
  int                m_dist;
  int                m_ones;
  int                m_cnt;
  int                m_target;

  function automatic int weight(input logic [RESP_W-1:0] v);
    int n = 0;
    for (int w = 0; w < RESP_W / 32; w++) n += $countones(v[w*32 +: 32]);
    return n;
  endfunction

  function automatic logic [RESP_W-1:0] rand_word();
    logic [RESP_W-1:0] r;
    for (int w = 0; w < RESP_W / 32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [RESP_W-1:0] sparse_noise();
    logic [RESP_W-1:0] r;
    for (int w = 0; w < RESP_W / 32; w++) r[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
    return r;
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [RESP_W-1:0] act, input logic [RESP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear(input int t);
    m_armed = 1'b1; m_golden = '0; m_mask = '0;
    m_dist = 0; m_ones = 0; m_cnt = 0; m_target = t;
  endtask

  task automatic model_take(input logic [RESP_W-1:0] r);
    if (m_armed) begin
      m_armed = 1'b0; m_golden = r; m_ones = weight(r);
    end else if (m_cnt < m_target) begin
      m_cnt++; m_mask |= (r ^ m_golden); m_dist += weight(r ^ m_golden);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic do_clear(input int t);
    clr = 1'b1; target_cnt = CNT_W'(t);
    @(negedge clk);
    clr = 1'b0;
    model_clear(t);
  endtask

  task automatic send(input logic [RESP_W-1:0] r);
    in_resp = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_take(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check_int({req, " dist_total"}, int'(dist_total), m_dist);
    check_vec({req, " unstable_mask"}, unstable_mask, m_mask);
    check_int({req, " unstable_cnt"}, int'(unstable_cnt), weight(m_mask));
    check_int({req, " ones_cnt"}, int'(ones_cnt), m_ones);
  endtask

  initial begin
    #1_200_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RESP_W-1:0] g;
    logic [RESP_W-1:0] r;
    void'($urandom(32'h5eed_0c1a));
    model_clear(1000);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check_all("R1 reset");
    check_int("R1 reset done", int'(done), 0);

    // R2/R3/R4/R5/R6: short run of 5 comparisons
    do_clear(5);
    g = rand_word();
    send(g);
    idle(4);
    check_all("R2 golden capture");
    for (int i = 0; i < 5; i++) send(g ^ sparse_noise());
    check_int("R6 done low while in flight", int'(done), 0);
    wait_done();
    check_int("R6 done after 5", int'(done), 1);
    check_all("R3 R4 R5 short run");

    // R7: responses after done are ignored
    send(~g); send(rand_word()); send(~g);
    idle(6);
    check_all("R7 after done");
    check_int("R7 done held", int'(done), 1);

    // R1: clear zeroes everything
    do_clear(3);
    check_all("R1 after clear");
    check_int("R1 clear done", int'(done), 0);

    // R9 latency and R5 all cells unstable
    send({RESP_W{1'b1}});
    check_int("R2 all ones", int'(ones_cnt), 128);
    in_resp = '0; in_valid = 1'b1;
    @(negedge clk);                       // first edge accepts
    in_valid = 1'b0;
    model_take('0);
    check_vec("R9 mask on accept edge", unstable_mask, {RESP_W{1'b1}});
    check_int("R5 all unstable", int'(unstable_cnt), 128);
    idle(2);                              // second and third edges
    check_int("R9 dist before fourth edge", int'(dist_total), 0);
    idle(1);                              // fourth edge
    check_int("R9 dist on fourth edge", int'(dist_total), 128);

    // R8: clr flushes in-flight work and wins over a same-cycle response
    do_clear(2);
    g = rand_word();
    send(g);
    send(~g);
    clr = 1'b1; target_cnt = CNT_W'(2);
    in_resp = rand_word(); in_valid = 1'b1;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    model_clear(2);
    idle(6);
    check_int("R8 flushed dist", int'(dist_total), 0);
    check_int("R8 flushed ones", int'(ones_cnt), 0);
    r = rand_word();
    send(r);
    idle(3);
    check_int("R8 next is golden", int'(ones_cnt), weight(r));
    check_int("R8 not compared", int'(dist_total), 0);

    // R10: zero-length run
    do_clear(0);
    g = rand_word();
    send(g);
    idle(2);
    check_int("R10 done at zero target", int'(done), 1);
    send(~g);
    idle(5);
    check_all("R10 nothing compared");

    // R3/R4/R5/R6: long random run with gaps
    do_clear(1000);
    g = rand_word();
    send(g);
    for (int i = 0; i < 1003; i++) begin
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      if (($urandom % 50) == 0) send(g);
      else send(g ^ sparse_noise());
      if (i == 500) check_int("R6 done low mid run", int'(done), 0);
    end
    wait_done();
    check_int("R6 done after 1000", int'(done), 1);
    check_all("R3 R4 R5 long run");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule